// File: doc/BRIEF.md
# Legacy Memory Segment Access Steering

This block decides where each access into the legacy window between 768 KB and 1 MB is sent. An access goes either to main memory or to a downstream I/O port. The window is split into thirteen segments: twelve 16 KB segments cover 0C0000h–0EFFFFh and one 64 KB segment covers 0F0000h–0FFFFFh. Each segment has a read-enable bit and a write-enable bit, so it can be mapped for reads only, for writes only, for both, or for neither. These rules apply the same way to host accesses and to accesses from peer initiators. Any address outside the window always goes to memory.

Software programs the segment attributes through seven byte-wide registers at configuration offsets 90h to 96h, using a single-cycle write strobe and a combinational read path. A lock input freezes all attribute bits. For each valid access, the block returns a registered decision one cycle later. It also raises an error flag when a peer initiator touches a segment that is not fully read/write enabled, so the system can discard that access instead of stalling.

Top module: `legacy_steer`

## Requirements
- R1: After reset, every attribute register reads 00h and every access inside the window is steered to the port (`dec_to_mem`=0).
- R2: A read inside a segment goes to memory exactly when that segment's read-enable bit (bit 0 of its 2-bit field) is 1; otherwise it goes to the port.
- R3: A write inside a segment goes to memory exactly when that segment's write-enable bit (bit 1 of its 2-bit field) is 1; otherwise it goes to the port.
- R4: Offset 90h bits 5:4 hold the field for 0F0000h–0FFFFFh. Offsets 91h–96h each hold two 16 KB segments in ascending address order starting at 0C0000h. In each of these registers, bits 1:0 control the lower segment and bits 5:4 the upper one.
- R5: Reserved bits (7:6 and 3:0 at 90h; 7:6 and 3:2 at 91h–96h) read as zero, whatever value was written to them.
- R6: While `lock` is 1, configuration writes leave every attribute bit unchanged.
- R7: An access below 0C0000h or at or above 100000h goes to memory and never raises the error flag.
- R8: `dec_valid` is 1 in the cycle after a clock edge that sees `acc_valid`=1 and 0 otherwise. `dec_to_mem` and `dec_peer_err` refer to that access.
- R9: `dec_peer_err` is 1 exactly when the access was peer-originated, fell inside the window, and its segment field is not 11. Host accesses never raise it.
- R10: Writes to offsets outside 90h–96h change no attribute, and reads of such offsets return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock | input | 1 | Freezes attribute registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_peer | input | 1 | 1 = peer initiator, 0 = host |
| dec_valid | output | 1 | Decision strobe |
| dec_to_mem | output | 1 | 1 = memory, 0 = downstream port |
| dec_peer_err | output | 1 | Illegal peer access flag |

## Verification
A configuration write takes effect at the clock edge where its strobe is sampled. The read path is combinational, so the bench checks read-back a fraction of a cycle after it sets the offset. An access decision arrives exactly one edge after the access is presented. The bench presents each access on a falling edge and checks `dec_valid`, `dec_to_mem` and `dec_peer_err` on the next falling edge, against a model that has already applied every earlier write. On the following idle falling edge, it checks that `dec_valid` has dropped back to 0.

// File: rtl/legacy_steer.sv
module legacy_steer #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter logic [7:0] BASE = 8'h90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          acc_peer,
  output logic          dec_valid,
  output logic          dec_to_mem,
  output logic          dec_peer_err
);
  localparam int NSEG = 13;
  localparam int NREG = 7;
  localparam int TOP  = NSEG - 1;

  logic [2*NSEG-1:0] attr_q;
  logic [CW-1:0]     idx;
  logic              hit;
  int                k;

  assign idx = cfg_addr - CW'(BASE);
  assign hit = (cfg_addr >= CW'(BASE)) && (idx < CW'(NREG));
  assign k   = int'(idx);

  always_ff @(posedge clk) begin
    if (!rst_n) attr_q <= '0;
    else if (cfg_we && !lock && hit) begin
      if (k == 0) attr_q[2*TOP +: 2] <= cfg_wdata[5:4];
      else begin
        attr_q[4*k-4 +: 2] <= cfg_wdata[1:0];
        attr_q[4*k-2 +: 2] <= cfg_wdata[5:4];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit) begin
      if (k == 0) cfg_rdata[5:4] = attr_q[2*TOP +: 2];
      else begin
        cfg_rdata[1:0] = attr_q[4*k-4 +: 2];
        cfg_rdata[5:4] = attr_q[4*k-2 +: 2];
      end
    end
  end

  logic       in_win;
  logic [3:0] seg;
  logic [1:0] fld;
  logic       go_mem;

  assign in_win = (acc_addr[AW-1:20] == '0) && (acc_addr[19:18] == 2'b11);
  assign seg    = (acc_addr[17:16] == 2'b11) ? 4'(TOP) : acc_addr[17:14];
  assign fld    = attr_q[2*seg +: 2];
  assign go_mem = !in_win || (acc_write ? fld[1] : fld[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_to_mem   <= 1'b0;
      dec_peer_err <= 1'b0;
    end else begin
      dec_valid    <= acc_valid;
      dec_to_mem   <= acc_valid && go_mem;
      dec_peer_err <= acc_valid && acc_peer && in_win && (fld != 2'b11);
    end
  end
endmodule

module legacy_steer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          acc_peer,
  input logic          dec_valid,
  input logic          dec_to_mem,
  input logic          dec_peer_err,
  input logic [25:0]   attr_q
);
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> dec_valid);
  assert_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dec_valid);
  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(attr_q));
  assert_outside_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr < AW'(32'h000C0000)) |=> (dec_to_mem && !dec_peer_err));
  assert_host_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_peer) |=> !dec_peer_err);
  assert_err_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_peer_err |-> dec_valid);
endmodule

bind legacy_steer legacy_steer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .acc_peer(acc_peer), .dec_valid(dec_valid),
  .dec_to_mem(dec_to_mem), .dec_peer_err(dec_peer_err), .attr_q(attr_q)
);

// File: tb/legacy_steer_test.sv
module legacy_steer_test;
  logic clk = 0, rst_n = 0, lock = 0, cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic acc_valid = 0, acc_write = 0, acc_peer = 0;
  logic [31:0] acc_addr = 0;
  logic dec_valid, dec_to_mem, dec_peer_err;
  int total = 0, bad = 0;
  int m[13];
  bit done = 0;

  always #2.5 clk = ~clk;

  legacy_steer uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int ofs);
    if (ofs == 'h90) return m[12] << 4;
    if (ofs > 'h90 && ofs <= 'h96) return m[2*(ofs-'h91)] | (m[2*(ofs-'h91)+1] << 4);
    return 0;
  endfunction

  function automatic int seg_of(longint a);
    if (a < 'hC0000 || a >= 'h100000) return -1;
    if (a >= 'hF0000) return 12;
    return int'((a - 'hC0000) / 'h4000);
  endfunction

  task automatic cfg_wr(int ofs, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'(ofs); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
    if (!lock) begin
      if (ofs == 'h90) m[12] = (d >> 4) & 3;
      else if (ofs > 'h90 && ofs <= 'h96) begin
        m[2*(ofs-'h91)]   = d & 3;
        m[2*(ofs-'h91)+1] = (d >> 4) & 3;
      end
    end
  endtask

  task automatic cfg_chk(string req, int ofs);
    cfg_addr = 8'(ofs);
    #1 chk(req, cfg_rdata, exp_rd(ofs));
  endtask

  task automatic access(string req, logic [31:0] a, bit wr, bit peer);
    int s, f, em, ee;
    s = seg_of(a);
    f = (s < 0) ? 3 : m[s];
    em = (s < 0) ? 1 : (wr ? (f >> 1) & 1 : f & 1);
    ee = (peer && s >= 0 && f != 3) ? 1 : 0;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = wr; acc_peer = peer;
    @(negedge clk);
    acc_valid = 0;
    chk({req, "_R8"}, dec_valid, 1);
    chk(req, dec_to_mem, em);
    chk({req, "_R9"}, dec_peer_err, ee);
    @(negedge clk);
    chk("R8 idle", dec_valid, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 13; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int o = 'h90; o <= 'h96; o++) cfg_chk("R1 reset rdata", o);
    access("R1 reset F seg", 32'hF8000, 0, 0);
    access("R1 reset C seg", 32'hC0000, 1, 0);

    for (int s = 0; s < 13; s++)
      for (int e = 0; e < 4; e++) begin
        longint a;
        int ofs, d;
        a = (s == 12) ? 'hF0000 + 'h1234 * e : 'hC0000 + s * 'h4000 + 'h3FF0 * (e & 1);
        if (s == 12) begin ofs = 'h90; d = e << 4; end
        else begin
          ofs = 'h91 + s / 2;
          d = (s % 2) ? (m[s-1] | (e << 4)) : (e | (m[s+1] << 4));
        end
        cfg_wr(ofs, d);
        cfg_chk("R4 map", ofs);
        access("R2 read", 32'(a), 0, 0);
        access("R3 write", 32'(a), 1, 0);
        access("R9 peer read", 32'(a), 0, 1);
        access("R9 peer write", 32'(a), 1, 1);
      end

    cfg_wr('h90, 'hFF); cfg_chk("R5 reserved 90", 'h90);
    cfg_wr('h93, 'hFF); cfg_chk("R5 reserved 93", 'h93);

    cfg_wr('h8F, 'hFF); cfg_wr('h97, 'hFF);
    cfg_chk("R10 offset 8F", 'h8F); cfg_chk("R10 offset 97", 'h97);
    for (int o = 'h90; o <= 'h96; o++) cfg_chk("R10 neighbours", o);

    cfg_wr('h91, 'h00);
    lock = 1;
    for (int o = 'h90; o <= 'h96; o++) cfg_wr(o, o[0] ? 'h11 : 'h22);
    for (int o = 'h90; o <= 'h96; o++) cfg_chk("R6 locked", o);
    access("R6 locked seg0", 32'hC0000, 0, 0);
    lock = 0;
    cfg_wr('h91, 'h31); cfg_chk("R6 unlocked", 'h91);

    access("R7 below", 32'hBFFFF, 0, 1);
    access("R7 low", 32'h00000, 1, 1);
    access("R7 above", 32'h100000, 1, 1);
    access("R7 high", 32'h8000_0000, 0, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule